// File: doc/BRIEF.md
# Raster Sync and Blank Generator with Write Key

This block produces the raster timing for a display pipeline. It keeps a pixel counter and a line counter. It compares them with positions held in software-visible registers and drives horizontal sync, vertical sync and blanking for a CRT path. It drives a second pair of syncs and a display-enable for a flat-panel path. Separate panel sync registers let the panel vsync be placed one line ahead of the CRT vsync.

Software reaches the block through a simple 32-bit register port: a write strobe with address and data, and a read data bus driven combinationally from the address. The timing and enable registers are protected by a write key. Writes to them have no effect until the key value has been written to the lock register, and any other value written there locks them again. Every position is stored as its pixel or line index minus one. The start or active value sits in the low half-word and the end or total value in the high half-word.

Top module: `raster_timing_gen`

## Requirements
- R1: After reset the block is locked, all registers read zero, `crt_blank` is 1, all syncs and `pnl_de` are 0, and both counters are 0.
- R2: Writing 0x00004758 to address 0x00 unlocks the block, and writing any other value there locks it. While locked, writes to any other address leave the stored registers and the outputs unchanged.
- R3: Reads return the stored value whether the block is locked or not. Address 0x00 reads 1 when unlocked and 0 when locked. Address 0x08 returns only bits 0,1,2,3,5. Timing registers return all 32 bits. Any other address reads 0.
- R4: While running, `pix_x` counts 0 up to the stored horizontal total (high half of 0x30) and then wraps to 0. `line_y` steps on each pixel wrap and wraps to 0 after the stored vertical total (high half of 0x40).
- R5: With config bit 5 (generator enable) clear, both counters hold their values, `crt_blank` is 1, and all syncs and `pnl_de` are 0.
- R6: With config bit 3 (blank enable) set, `crt_blank` is 1 when `pix_x` lies in (lo,hi] of 0x34 or `line_y` lies in (lo,hi] of 0x44. With bit 3 clear and the generator running, `crt_blank` is 0.
- R7: `crt_hsync` is 1 exactly when config bit 1 is set and `pix_x` lies in (lo,hi] of 0x38. `crt_vsync` is 1 exactly when config bit 2 is set and `line_y` lies in (lo,hi] of 0x48. Both are active-high.
- R8: With config bit 0 (panel enable) set, `pnl_hsync` follows (lo,hi] of 0x3C on `pix_x` and `pnl_vsync` follows (lo,hi] of 0x4C on `line_y`. `pnl_de` is 1 when `pix_x` is at most the low half of 0x30 and `line_y` is at most the low half of 0x40. With bit 0 clear, all three are 0.
- R9: A register write takes effect from the clock edge that accepts it. A newly enabled generator shows `pix_x`=0 right after that edge and steps on each following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel and register clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| unlocked | output | 1 | Write key accepted |
| pix_x | output | CNT_W | Current pixel index in the line |
| line_y | output | CNT_W | Current line index in the frame |
| crt_hsync | output | 1 | CRT horizontal sync, active-high |
| crt_vsync | output | 1 | CRT vertical sync, active-high |
| crt_blank | output | 1 | CRT blanking |
| pnl_hsync | output | 1 | Panel horizontal sync |
| pnl_vsync | output | 1 | Panel vertical sync |
| pnl_de | output | 1 | Panel display enable |

## Verification
The bench programs an 11-pixel by 8-line raster. It then checks every output on every cycle over whole frames with four enable patterns. With all enables set, it separates the sync, blank and panel windows from each other and shows that the panel vsync is one line early. With sync enables clear, it shows the syncs are gated. With blank enable clear, it shows blanking is gated. A partial run followed by a stop shows the counters freeze mid-frame. Wrong keys, relocking and locked writes are each followed by read-back and output checks, to show that nothing changed.

// File: rtl/tg_pkg.sv
package tg_pkg;
  localparam int          FIELD_W   = 16;
  localparam int          NUM_TREG  = 8;
  localparam logic [7:0]  A_LOCK    = 8'h00;
  localparam logic [7:0]  A_CFG     = 8'h08;
  localparam logic [7:0]  A_TBASE   = 8'h30;
  localparam logic [31:0] WR_KEY    = 32'h0000_4758;

  // timing register slots, address = A_TBASE + 4*index
  localparam int I_H_AT = 0;  // active / total
  localparam int I_H_BL = 1;  // blank start / end
  localparam int I_H_SY = 2;  // crt sync start / end
  localparam int I_P_HS = 3;  // panel hsync
  localparam int I_V_AT = 4;
  localparam int I_V_BL = 5;
  localparam int I_V_SY = 6;
  localparam int I_P_VS = 7;

  typedef struct packed {
    logic [FIELD_W-1:0] hi;
    logic [FIELD_W-1:0] lo;
  } span_t;

  typedef struct packed {
    logic tgen;  // bit 5
    logic blk;   // bit 3
    logic vs;    // bit 2
    logic hs;    // bit 1
    logic pnl;   // bit 0
  } cfg_t;

  function automatic logic in_span(input logic [FIELD_W-1:0] pos, input span_t s);
    return (pos > s.lo) && (pos <= s.hi);
  endfunction
endpackage

// File: rtl/tg_regs.sv
module tg_regs
  import tg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [7:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        unlocked,
  output cfg_t        cfg,
  output span_t       spans [NUM_TREG]
);
  logic [NUM_TREG-1:0] hit;

  for (genvar i = 0; i < NUM_TREG; i++) begin : g_hit
    localparam logic [7:0] ADDR = A_TBASE + 8'(i * 4);
    assign hit[i] = (reg_addr == ADDR);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      unlocked <= 1'b0;
      cfg      <= '0;
      for (int i = 0; i < NUM_TREG; i++) spans[i] <= '0;
    end else if (reg_wr) begin
      if (reg_addr == A_LOCK) begin
        unlocked <= (reg_wdata == WR_KEY);
      end else if (unlocked) begin
        if (reg_addr == A_CFG) begin
          cfg.pnl  <= reg_wdata[0];
          cfg.hs   <= reg_wdata[1];
          cfg.vs   <= reg_wdata[2];
          cfg.blk  <= reg_wdata[3];
          cfg.tgen <= reg_wdata[5];
        end
        for (int i = 0; i < NUM_TREG; i++)
          if (hit[i]) spans[i] <= span_t'(reg_wdata);
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == A_LOCK) reg_rdata = {31'd0, unlocked};
    if (reg_addr == A_CFG)
      reg_rdata = {26'd0, cfg.tgen, 1'b0, cfg.blk, cfg.vs, cfg.hs, cfg.pnl};
    for (int i = 0; i < NUM_TREG; i++)
      if (hit[i]) reg_rdata = spans[i];
  end
endmodule

// File: rtl/tg_counter.sv
module tg_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic [W-1:0] limit,
  output logic [W-1:0] count,
  output logic         wrap
);
  logic at_end;

  // >= so that a total reprogrammed below the count still wraps
  assign at_end = (count >= limit);
  assign wrap   = step && at_end;

  always_ff @(posedge clk) begin
    if (!rst_n)    count <= '0;
    else if (step) count <= at_end ? '0 : count + 1'b1;
  end
endmodule

// File: rtl/tg_decode.sv
module tg_decode
  import tg_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  cfg_t             cfg,
  input  span_t            spans [NUM_TREG],
  input  logic [CNT_W-1:0] pix_x,
  input  logic [CNT_W-1:0] line_y,
  output logic             crt_hsync,
  output logic             crt_vsync,
  output logic             crt_blank,
  output logic             pnl_hsync,
  output logic             pnl_vsync,
  output logic             pnl_de
);
  logic [FIELD_W-1:0] x, y;
  logic hb, vb, hact, vact;

  assign x = FIELD_W'(pix_x);
  assign y = FIELD_W'(line_y);

  assign hb   = in_span(x, spans[I_H_BL]);
  assign vb   = in_span(y, spans[I_V_BL]);
  assign hact = (x <= spans[I_H_AT].lo);
  assign vact = (y <= spans[I_V_AT].lo);

  assign crt_blank = !cfg.tgen || (cfg.blk && (hb || vb));
  assign crt_hsync = cfg.tgen && cfg.hs && in_span(x, spans[I_H_SY]);
  assign crt_vsync = cfg.tgen && cfg.vs && in_span(y, spans[I_V_SY]);
  assign pnl_hsync = cfg.tgen && cfg.pnl && in_span(x, spans[I_P_HS]);
  assign pnl_vsync = cfg.tgen && cfg.pnl && in_span(y, spans[I_P_VS]);
  assign pnl_de    = cfg.tgen && cfg.pnl && hact && vact;
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import tg_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [7:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  output logic             unlocked,
  output logic [CNT_W-1:0] pix_x,
  output logic [CNT_W-1:0] line_y,
  output logic             crt_hsync,
  output logic             crt_vsync,
  output logic             crt_blank,
  output logic             pnl_hsync,
  output logic             pnl_vsync,
  output logic             pnl_de
);
  localparam int FLAT_W = NUM_TREG * 32;

  cfg_t              cfg_w;
  span_t             spans_w [NUM_TREG];
  logic              h_wrap, v_wrap;
  logic [FLAT_W-1:0] treg_flat;

  tg_regs u_regs (
    .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
    .unlocked, .cfg(cfg_w), .spans(spans_w)
  );

  tg_counter #(.W(CNT_W)) u_hcnt (
    .clk, .rst_n, .step(cfg_w.tgen),
    .limit(CNT_W'(spans_w[I_H_AT].hi)), .count(pix_x), .wrap(h_wrap)
  );

  tg_counter #(.W(CNT_W)) u_vcnt (
    .clk, .rst_n, .step(h_wrap),
    .limit(CNT_W'(spans_w[I_V_AT].hi)), .count(line_y), .wrap(v_wrap)
  );

  tg_decode #(.CNT_W(CNT_W)) u_dec (
    .cfg(cfg_w), .spans(spans_w), .pix_x, .line_y,
    .crt_hsync, .crt_vsync, .crt_blank, .pnl_hsync, .pnl_vsync, .pnl_de
  );

  for (genvar i = 0; i < NUM_TREG; i++) begin : g_flat
    assign treg_flat[i*32 +: 32] = spans_w[i];
  end
endmodule

// File: rtl/tg_checker.sv
module tg_checker
  import tg_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int FLAT_W = 256
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic [7:0]       reg_addr,
  input logic [31:0]      reg_wdata,
  input logic             unlocked,
  input cfg_t             cfg,
  input logic [FLAT_W-1:0] treg_flat,
  input logic [CNT_W-1:0] pix_x,
  input logic [CNT_W-1:0] line_y,
  input logic             v_wrap,
  input logic             crt_blank,
  input logic             crt_hsync,
  input logic             crt_vsync,
  input logic             pnl_de
);
  logic [FIELD_W-1:0] h_total;
  assign h_total = treg_flat[FIELD_W +: FIELD_W];

  AST_LOCKED_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlocked && reg_wr && reg_addr != A_LOCK) |=> ($stable(treg_flat) && $stable(cfg))); // R2
  AST_KEY_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_LOCK && reg_wdata == WR_KEY) |=> unlocked); // R2
  AST_COUNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg.tgen |=> ($stable(pix_x) && $stable(line_y))); // R5
  AST_IDLE_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg.tgen |-> (crt_blank && !pnl_de && !crt_hsync && !crt_vsync)); // R5
  AST_SYNC_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg.hs |-> !crt_hsync) and (!cfg.vs |-> !crt_vsync)); // R7
  AST_PIX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.tgen && FIELD_W'(pix_x) < h_total) |=> pix_x == CNT_W'($past(pix_x) + 1'b1)); // R4
  AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    v_wrap |=> (pix_x == '0 && line_y == '0)); // R4
endmodule

bind raster_timing_gen tg_checker #(.CNT_W(CNT_W), .FLAT_W(FLAT_W)) u_tg_checker (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .unlocked(unlocked), .cfg(cfg_w), .treg_flat(treg_flat),
  .pix_x(pix_x), .line_y(line_y), .v_wrap(v_wrap), .crt_blank(crt_blank),
  .crt_hsync(crt_hsync), .crt_vsync(crt_vsync), .pnl_de(pnl_de)
);

// File: tb/tb_raster_timing_gen.sv
`timescale 1ns/1ps
module tb_raster_timing_gen;
  localparam int HT = 11, VT = 8, HACT = 6, VACT = 4;
  localparam logic [31:0] KEY = 32'h0000_4758;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        unlocked;
  logic [15:0] pix_x, line_y;
  logic        crt_hsync, crt_vsync, crt_blank, pnl_hsync, pnl_vsync, pnl_de;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  raster_timing_gen dut (
    .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata, .unlocked,
    .pix_x, .line_y, .crt_hsync, .crt_vsync, .crt_blank,
    .pnl_hsync, .pnl_vsync, .pnl_de
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string req);
    reg_addr = a;
    #1;
    check(reg_rdata == exp, req, 64'(reg_rdata), 64'(exp));
  endtask

  function automatic logic [63:0] model(input int k, input logic [5:0] c);
    int x = k % HT;
    int y = (k / HT) % VT;
    logic bl, hs, vs, ph, pv, de;
    bl = c[3] && (x >= HACT || y >= VACT);
    hs = c[1] && (x >= 7 && x < 9);
    vs = c[2] && (y == 5);
    ph = c[0] && (x >= 7 && x < 9);
    pv = c[0] && (y == 4);
    de = c[0] && (x < HACT && y < VACT);
    return {26'd0, 16'(x), 16'(y), bl, hs, vs, ph, pv, de};
  endfunction

  function automatic logic [63:0] observed();
    return {26'd0, pix_x, line_y, crt_blank, crt_hsync, crt_vsync, pnl_hsync, pnl_vsync, pnl_de};
  endfunction

  // R4 R6 R7 R8 R9: cycle-exact sweep from a frame-aligned start
  task automatic sweep(input logic [5:0] c, input int n, input string req);
    wr(8'h08, {26'd0, c});
    for (int k = 0; k < n; k++) begin
      check(observed() == model(k, c), req, observed(), model(k, c));
      if (k < n - 1) @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd_chk(8'h00, 32'h0, "R1 lock");
    rd_chk(8'h08, 32'h0, "R1 cfg");
    rd_chk(8'h30, 32'h0, "R1 treg");
    check(crt_blank && !crt_hsync && !crt_vsync && !pnl_de && !pnl_hsync && pix_x == 0 && line_y == 0,
          "R1 outputs", observed(), 64'h0);
    // R2 locked writes ignored before key
    wr(8'h30, 32'h0012_0034);
    rd_chk(8'h30, 32'h0, "R2 locked write");
    wr(8'h00, KEY);
    rd_chk(8'h00, 32'h1, "R2 unlock");
    check(unlocked, "R2 unlocked pin", 64'(unlocked), 64'h1);
    // program 11x8 raster, positions minus one, low=start high=end
    wr(8'h30, {16'd10, 16'd5});
    wr(8'h34, {16'd10, 16'd5});
    wr(8'h38, {16'd8,  16'd6});
    wr(8'h3C, {16'd8,  16'd6});
    wr(8'h40, {16'd7,  16'd3});
    wr(8'h44, {16'd7,  16'd3});
    wr(8'h48, {16'd5,  16'd4});
    wr(8'h4C, {16'd4,  16'd3});  // panel vsync one line ahead
    rd_chk(8'h48, 32'h0005_0004, "R3 field layout");
    sweep(6'h2F, 2 * HT * VT, "R4 R6 R7 R8 R9 all enables");
    sweep(6'h28, HT * VT, "R7 R8 syncs and panel off");
    sweep(6'h27, HT * VT, "R6 blank enable off");
    sweep(6'h2F, 13, "R4 partial frame");
    wr(8'h08, 32'h0F);  // stop: last step lands on k=13
    for (int i = 0; i < 4; i++) begin
      check(observed() == {26'd0, 16'd2, 16'd1, 6'b100000}, "R5 frozen idle",
            observed(), {26'd0, 16'd2, 16'd1, 6'b100000});
      @(negedge clk);
    end
    // R2 relock and wrong key
    wr(8'h00, 32'h0);
    rd_chk(8'h00, 32'h0, "R2 relock");
    wr(8'h30, 32'hDEAD_BEEF);
    rd_chk(8'h30, 32'h000A_0005, "R2 R3 locked read-back");
    wr(8'h08, 32'h2F);
    rd_chk(8'h08, 32'h0F, "R2 cfg unchanged");
    @(negedge clk);
    check(pix_x == 2 && crt_blank, "R2 outputs unchanged", observed(), {26'd0, 16'd2, 16'd1, 6'b100000});
    wr(8'h00, KEY + 1);
    rd_chk(8'h00, 32'h0, "R2 wrong key");
    wr(8'h00, KEY);
    rd_chk(8'h00, 32'h1, "R2 key again");
    rd_chk(8'h10, 32'h0, "R3 unmapped");
    rd_chk(8'h04, 32'h0, "R3 unmapped low");
    wr(8'h08, 32'hFFFF_FFFF);
    rd_chk(8'h08, 32'h2F, "R3 cfg mask");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule